// File: doc/BRIEF.md
# Grouped Double-Buffered Pulse Output Register

This block drives sixteen pulse output pins from an output data register. The register is loaded from a staging copy, the next-data register, on compare-match events. The pins are split into four 4-bit groups. Group 0 is bits 3:0, group 1 is bits 7:4, group 2 is bits 11:8 and group 3 is bits 15:12. Each group has a 2-bit trigger selector that picks one of four compare-match pulse inputs. When the selected pulse arrives, the staged nibble is copied into the output bits of that group, but only into the bits whose pulse enable is set. Software prepares the next pattern over a byte-wide register bus ahead of time, so that the pins change on the exact cycle of the timer event.

The next-data address map depends on the trigger selectors. When the two groups of a byte share a selector, the whole byte sits at one address. When they differ, each nibble has its own address. Output bits that are enabled for pulse output cannot be written from the bus. A hardware standby input clears both registers. A software standby input freezes all state, so bus writes and triggers have no effect while it is high.

Top module: `pulse_out_unit`

## Requirements
- R1: After reset, pulseOut is 0x0000, and the output data and next-data registers read 0x00 at addresses 0, 1, 2 and 3.
- R2: A cycle with hwStandby high clears pulseOut and both next-data bytes to zero on the next clock edge.
- R3: While swStandby is high, bus writes and triggers are ignored, and pulseOut and the next-data contents hold their values.
- R4: Group g (bits 4g+3:4g) uses selector field trigSel[2g+1:2g]. When trigIn[selector] is high at a clock edge, the enabled bits of the group take the next-data nibble at that edge. Groups whose selected input is low do not change.
- R5: A transfer copies only the bits whose pulseEn bit is 1. Bits with pulseEn 0 keep their output value.
- R6: Address 0 reads and writes output bits 15:8, and address 1 reads and writes output bits 7:0. A write changes only the bits whose pulseEn is 0.
- R7: Shared mode for a byte holds when trigSel[7:6]==trigSel[5:4] for the high byte (groups 3 and 2) or trigSel[3:2]==trigSel[1:0] for the low byte (groups 1 and 0). In shared mode the whole next-data byte is read and written at the primary address: 2 for the high byte, 3 for the low byte. The alternate address (4 for high, 5 for low) reads 0xFF and ignores writes.
- R8: When the two groups of a byte use different selectors, the primary address holds the upper group in bits 7:4, and its bits 3:0 read as ones. The alternate address holds the lower group in bits 3:0, and its bits 7:4 read as ones.
- R9: If a next-data write and a trigger for the same group occur in the same cycle, the output takes the old next-data value, and the new value is stored for the next trigger.
- R10: All groups whose selectors are equal transfer in the same cycle.
- R11: Addresses 6 and 7 read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hwStandby | input | 1 | Synchronous clear of all registers |
| swStandby | input | 1 | Freezes all register state |
| busAddr | input | 3 | Register address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for busAddr |
| trigIn | input | 4 | Compare-match pulses, one cycle each |
| trigSel | input | 8 | Per-group 2-bit trigger selectors, group g in bits 2g+1:2g |
| pulseEn | input | 16 | Per-bit pulse output enable |
| pulseOut | output | 16 | Pulse output pins |

## Verification
Transfers are tried in three patterns. With all groups on one selector, a single pulse must update every group, which separates the shared transfer from a per-group transfer. With four distinct selectors, one pulse at a time must move exactly one nibble, which exposes wrong selector-to-group wiring. With a partial enable mask, the test separates masked copy and masked bus write from unmasked behaviour. The address decode is read and written in both shared and split mode, so that a wrong choice of reserved nibble shows up directly in the read data. A write coinciding with a trigger distinguishes old-data transfer from write-through.

// File: rtl/pulse_out_pkg.sv
package pulse_out_pkg;
  localparam int PO_GROUPS = 4;
  localparam int PO_NIB_W  = 4;
  localparam int PO_WIDTH  = PO_GROUPS * PO_NIB_W;
  localparam int PO_BYTE_W = 2 * PO_NIB_W;
  localparam int PO_BYTES  = PO_WIDTH / PO_BYTE_W;
  localparam int PO_TRIGS  = 4;
  localparam int PO_SEL_W  = $clog2(PO_TRIGS);
  localparam int PO_ADDR_W = 3;

  typedef enum logic [1:0] {RD_ODR, RD_NDR, RD_ONES} rdSel_e;

  typedef struct packed {
    logic [PO_GROUPS-1:0] fire;
    logic [PO_GROUPS-1:0] ndrWr;
    logic [PO_BYTES-1:0]  odrWr;
    rdSel_e               rdSel;
    logic                 rdByte;
    logic [PO_BYTE_W-1:0] rdOnes;
  } poStrobe_t;

  function automatic logic [PO_ADDR_W-1:0] odrAddr(input int b);
    return (b == 1) ? PO_ADDR_W'(0) : PO_ADDR_W'(1);
  endfunction

  function automatic logic [PO_ADDR_W-1:0] ndrPrimAddr(input int b);
    return (b == 1) ? PO_ADDR_W'(2) : PO_ADDR_W'(3);
  endfunction

  function automatic logic [PO_ADDR_W-1:0] ndrAltAddr(input int b);
    return (b == 1) ? PO_ADDR_W'(4) : PO_ADDR_W'(5);
  endfunction
endpackage

// File: rtl/pulse_out_ctrl.sv
module pulse_out_ctrl
  import pulse_out_pkg::*;
(
  input  logic [PO_ADDR_W-1:0]          busAddr,
  input  logic                          busWrEn,
  input  logic                          swStandby,
  input  logic [PO_TRIGS-1:0]           trigIn,
  input  logic [PO_GROUPS*PO_SEL_W-1:0] trigSel,
  output poStrobe_t                     strobe
);
  localparam logic [PO_BYTE_W-1:0] LO_NIB_ONES = PO_BYTE_W'({PO_NIB_W{1'b1}});
  localparam logic [PO_BYTE_W-1:0] HI_NIB_ONES = ~LO_NIB_ONES;

  logic [PO_GROUPS-1:0] fireRaw;
  logic [PO_BYTES-1:0]  shareByte;
  logic [PO_GROUPS-1:0] ndrWrRaw;
  logic [PO_BYTES-1:0]  odrWrRaw;
  rdSel_e               rdSel;
  logic                 rdByte;
  logic [PO_BYTE_W-1:0] rdOnes;

  for (genvar g = 0; g < PO_GROUPS; g++) begin : gFire
    assign fireRaw[g] = trigIn[trigSel[g*PO_SEL_W +: PO_SEL_W]];
  end

  for (genvar b = 0; b < PO_BYTES; b++) begin : gShare
    assign shareByte[b] = (trigSel[(2*b+1)*PO_SEL_W +: PO_SEL_W] ==
                           trigSel[(2*b)*PO_SEL_W +: PO_SEL_W]);
  end

  always_comb begin
    ndrWrRaw = '0;
    odrWrRaw = '0;
    rdSel    = RD_ONES;
    rdByte   = 1'b0;
    rdOnes   = '1;
    for (int b = 0; b < PO_BYTES; b++) begin
      if (busAddr == odrAddr(b)) begin
        odrWrRaw[b] = busWrEn;
        rdSel       = RD_ODR;
        rdByte      = b[0];
        rdOnes      = '0;
      end
      if (busAddr == ndrPrimAddr(b)) begin
        rdSel  = RD_NDR;
        rdByte = b[0];
        ndrWrRaw[2*b+1] = busWrEn;
        if (shareByte[b]) begin
          ndrWrRaw[2*b] = busWrEn;
          rdOnes        = '0;
        end else begin
          rdOnes = LO_NIB_ONES;
        end
      end
      if (busAddr == ndrAltAddr(b)) begin
        if (shareByte[b]) begin
          rdSel  = RD_ONES;
          rdOnes = '1;
        end else begin
          rdSel         = RD_NDR;
          rdByte        = b[0];
          ndrWrRaw[2*b] = busWrEn;
          rdOnes        = HI_NIB_ONES;
        end
      end
    end
  end

  always_comb begin
    strobe.fire   = swStandby ? '0 : fireRaw;
    strobe.ndrWr  = swStandby ? '0 : ndrWrRaw;
    strobe.odrWr  = swStandby ? '0 : odrWrRaw;
    strobe.rdSel  = rdSel;
    strobe.rdByte = rdByte;
    strobe.rdOnes = rdOnes;
  end
endmodule

// File: rtl/pulse_out_dp.sv
module pulse_out_dp
  import pulse_out_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hwStandby,
  input  poStrobe_t            strobe,
  input  logic [PO_BYTE_W-1:0] busWrData,
  input  logic [PO_WIDTH-1:0]  pulseEn,
  output logic [PO_WIDTH-1:0]  pulseOut,
  output logic [PO_BYTE_W-1:0] busRdData
);
  logic [PO_WIDTH-1:0] ndrFlat;
  logic [PO_WIDTH-1:0] odrFlat;

  for (genvar g = 0; g < PO_GROUPS; g++) begin : gGroup
    localparam int BYTE_IDX = g / 2;
    localparam int LANE     = (g % 2) * PO_NIB_W;

    logic [PO_NIB_W-1:0] ndrQ;
    logic [PO_NIB_W-1:0] odrQ;
    logic [PO_NIB_W-1:0] odrNext;
    logic [PO_NIB_W-1:0] en;

    assign en = pulseEn[g*PO_NIB_W +: PO_NIB_W];

    always_comb begin
      odrNext = odrQ;
      if (strobe.odrWr[BYTE_IDX])
        odrNext = (odrNext & en) | (busWrData[LANE +: PO_NIB_W] & ~en);
      if (strobe.fire[g])
        odrNext = (odrNext & ~en) | (ndrQ & en);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        ndrQ <= '0;
      else if (hwStandby)
        ndrQ <= '0;
      else if (strobe.ndrWr[g])
        ndrQ <= busWrData[LANE +: PO_NIB_W];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        odrQ <= '0;
      else if (hwStandby)
        odrQ <= '0;
      else
        odrQ <= odrNext;
    end

    assign ndrFlat[g*PO_NIB_W +: PO_NIB_W] = ndrQ;
    assign odrFlat[g*PO_NIB_W +: PO_NIB_W] = odrQ;
  end

  assign pulseOut = odrFlat;

  always_comb begin
    logic [PO_BYTE_W-1:0] raw;
    unique case (strobe.rdSel)
      RD_ODR:  raw = odrFlat[strobe.rdByte*PO_BYTE_W +: PO_BYTE_W];
      RD_NDR:  raw = ndrFlat[strobe.rdByte*PO_BYTE_W +: PO_BYTE_W];
      default: raw = '1;
    endcase
    busRdData = raw | strobe.rdOnes;
  end
endmodule

// File: rtl/pulse_out_unit.sv
module pulse_out_unit
  import pulse_out_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          hwStandby,
  input  logic                          swStandby,
  input  logic [PO_ADDR_W-1:0]          busAddr,
  input  logic                          busWrEn,
  input  logic [PO_BYTE_W-1:0]          busWrData,
  output logic [PO_BYTE_W-1:0]          busRdData,
  input  logic [PO_TRIGS-1:0]           trigIn,
  input  logic [PO_GROUPS*PO_SEL_W-1:0] trigSel,
  input  logic [PO_WIDTH-1:0]           pulseEn,
  output logic [PO_WIDTH-1:0]           pulseOut
);
  poStrobe_t strobe;

  pulse_out_ctrl i_ctrl (
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .swStandby(swStandby),
    .trigIn   (trigIn),
    .trigSel  (trigSel),
    .strobe   (strobe)
  );

  pulse_out_dp i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .hwStandby(hwStandby),
    .strobe   (strobe),
    .busWrData(busWrData),
    .pulseEn  (pulseEn),
    .pulseOut (pulseOut),
    .busRdData(busRdData)
  );
endmodule

// File: rtl/pulse_out_checker.sv
module pulse_out_checker
  import pulse_out_pkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic                          hwStandby,
  input logic                          swStandby,
  input logic [PO_ADDR_W-1:0]          busAddr,
  input logic                          busWrEn,
  input logic [PO_BYTE_W-1:0]          busRdData,
  input logic [PO_TRIGS-1:0]           trigIn,
  input logic [PO_GROUPS*PO_SEL_W-1:0] trigSel,
  input logic [PO_WIDTH-1:0]           pulseEn,
  input logic [PO_WIDTH-1:0]           pulseOut
);
  AST_HW_STANDBY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    hwStandby |=> (pulseOut == '0)); // R2

  AST_SW_STANDBY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (swStandby && !hwStandby) |=> $stable(pulseOut)); // R3

  AST_ENABLED_NEED_TRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    (trigIn == '0 && !hwStandby) |=> (((pulseOut ^ $past(pulseOut)) & $past(pulseEn)) == '0)); // R4

  AST_OUT_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (trigIn == '0 && !busWrEn && !hwStandby) |=> $stable(pulseOut)); // R6

  AST_SHARED_ALT_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 3'd4 && trigSel[7:6] == trigSel[5:4]) |-> (busRdData == 8'hFF)); // R7

  AST_UNMAPPED_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr >= 3'd6) |-> (busRdData == 8'hFF)); // R11
endmodule

bind pulse_out_unit pulse_out_checker i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hwStandby(hwStandby),
  .swStandby(swStandby),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .busRdData(busRdData),
  .trigIn   (trigIn),
  .trigSel  (trigSel),
  .pulseEn  (pulseEn),
  .pulseOut (pulseOut)
);

// File: tb/test_pulse_out_unit.sv
module test_pulse_out_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hwStandby = 1'b0;
  logic        swStandby = 1'b0;
  logic [2:0]  busAddr = 3'd0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = 8'h00;
  logic [7:0]  busRdData;
  logic [3:0]  trigIn = 4'h0;
  logic [7:0]  trigSel = 8'h00;
  logic [15:0] pulseEn = 16'h0000;
  logic [15:0] pulseOut;

  int checks = 0;
  int errors = 0;
  logic [15:0] mNdr = 16'h0000;
  logic [15:0] mOdr = 16'h0000;

  always #10 clk = ~clk;

  pulse_out_unit i_pulse_out_unit (
    .clk(clk), .rstN(rstN), .hwStandby(hwStandby), .swStandby(swStandby),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .trigIn(trigIn), .trigSel(trigSel),
    .pulseEn(pulseEn), .pulseOut(pulseOut)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void modelWrite(input logic [2:0] a, input logic [7:0] d);
    logic shHi = (trigSel[7:6] == trigSel[5:4]);
    logic shLo = (trigSel[3:2] == trigSel[1:0]);
    case (a)
      3'd0: mOdr[15:8] = (mOdr[15:8] & pulseEn[15:8]) | (d & ~pulseEn[15:8]);
      3'd1: mOdr[7:0]  = (mOdr[7:0] & pulseEn[7:0]) | (d & ~pulseEn[7:0]);
      3'd2: if (shHi) mNdr[15:8] = d; else mNdr[15:12] = d[7:4];
      3'd3: if (shLo) mNdr[7:0] = d; else mNdr[7:4] = d[7:4];
      3'd4: if (!shHi) mNdr[11:8] = d[3:0];
      3'd5: if (!shLo) mNdr[3:0] = d[3:0];
      default: ;
    endcase
  endfunction

  function automatic void modelTrig(input logic [3:0] mask);
    for (int g = 0; g < 4; g++) begin
      if (mask[trigSel[2*g +: 2]])
        mOdr[4*g +: 4] = (mOdr[4*g +: 4] & ~pulseEn[4*g +: 4]) |
                         (mNdr[4*g +: 4] & pulseEn[4*g +: 4]);
    end
  endfunction

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic fireTrig(input logic [3:0] mask);
    @(negedge clk);
    trigIn = mask;
    @(negedge clk);
    trigIn = 4'h0;
    modelTrig(mask);
  endtask

  task automatic checkRead(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    busAddr = a;
    #1;
    check(req, {8'h00, busRdData}, {8'h00, exp});
  endtask

  task automatic t_reset;
    check("R1 pulseOut", pulseOut, 16'h0000);
    checkRead("R1 addr0", 3'd0, 8'h00);
    checkRead("R1 addr1", 3'd1, 8'h00);
    checkRead("R1 addr2", 3'd2, 8'h00);
    checkRead("R1 addr3", 3'd3, 8'h00);
  endtask

  task automatic t_shared;
    trigSel = 8'h00; pulseEn = 16'hFFFF;
    busWrite(3'd2, 8'hA5);
    busWrite(3'd3, 8'h3C);
    busWrite(3'd4, 8'h55);
    checkRead("R7 alt hi ones", 3'd4, 8'hFF);
    checkRead("R7 alt lo ones", 3'd5, 8'hFF);
    checkRead("R7 prim hi", 3'd2, 8'hA5);
    checkRead("R7 prim lo", 3'd3, 8'h3C);
    fireTrig(4'h1);
    check("R10 all groups together", pulseOut, 16'hA53C);
  endtask

  task automatic t_split;
    trigSel = 8'b11_10_01_00;
    busWrite(3'd2, 8'h7B);
    checkRead("R8 prim hi", 3'd2, 8'h7F);
    busWrite(3'd4, 8'hC9);
    checkRead("R8 alt hi", 3'd4, 8'hF9);
    checkRead("R8 prim hi kept", 3'd2, 8'h7F);
    busWrite(3'd3, 8'h12);
    busWrite(3'd5, 8'h34);
    checkRead("R8 alt lo", 3'd5, 8'hF4);
    fireTrig(4'h4);
    check("R4 group2 only", pulseOut, 16'hA93C);
    check("R4 model", pulseOut, mOdr);
    fireTrig(4'h8);
    check("R4 group3 only", pulseOut, 16'h793C);
    fireTrig(4'h3);
    check("R4 groups 1 and 0", pulseOut, 16'h7914);
  endtask

  task automatic t_enable;
    pulseEn = 16'h00FF;
    busWrite(3'd0, 8'h5A);
    check("R6 hi writable", pulseOut, 16'h5A14);
    busWrite(3'd1, 8'hFF);
    check("R6 enabled bits read-only", pulseOut, 16'h5A14);
    checkRead("R6 read odr lo", 3'd1, 8'h14);
    checkRead("R6 read odr hi", 3'd0, 8'h5A);
    busWrite(3'd3, 8'h80);
    busWrite(3'd5, 8'h06);
    fireTrig(4'hF);
    check("R5 masked copy", pulseOut, 16'h5A86);
    check("R5 model", pulseOut, mOdr);
  endtask

  task automatic t_same_cycle;
    trigSel = 8'h00; pulseEn = 16'hFFFF;
    @(negedge clk);
    busAddr = 3'd3; busWrData = 8'hEE; busWrEn = 1'b1; trigIn = 4'h1;
    @(negedge clk);
    busWrEn = 1'b0; trigIn = 4'h0;
    modelTrig(4'h1);
    modelWrite(3'd3, 8'hEE);
    check("R9 old data transferred", pulseOut, 16'h7986);
    checkRead("R9 new data stored", 3'd3, 8'hEE);
    fireTrig(4'h1);
    check("R9 next transfer", pulseOut, 16'h79EE);
  endtask

  task automatic t_sw_standby;
    @(negedge clk);
    swStandby = 1'b1;
    busWrite(3'd2, 8'h11);
    busWrite(3'd0, 8'h00);
    @(negedge clk);
    trigIn = 4'h1;
    @(negedge clk);
    trigIn = 4'h0;
    check("R3 output held", pulseOut, 16'h79EE);
    checkRead("R3 ndr held", 3'd2, 8'h79);
    swStandby = 1'b0;
    mNdr[15:8] = 8'h79;
    mOdr = 16'h79EE;
  endtask

  task automatic t_hw_standby;
    @(negedge clk);
    hwStandby = 1'b1;
    @(negedge clk);
    hwStandby = 1'b0;
    mNdr = '0; mOdr = '0;
    check("R2 output cleared", pulseOut, 16'h0000);
    checkRead("R2 ndr hi cleared", 3'd2, 8'h00);
    checkRead("R2 ndr lo cleared", 3'd3, 8'h00);
  endtask

  task automatic t_unmapped;
    checkRead("R11 addr6", 3'd6, 8'hFF);
    checkRead("R11 addr7", 3'd7, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_shared();
    t_split();
    t_enable();
    t_same_cycle();
    t_sw_standby();
    t_hw_standby();
    t_unmapped();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule